// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns a CPU byte address into the multiplexed row and column lines of one DRAM bank, and it sequences the row and column strobes for a single access. Because the data path is 16 bits wide, the lowest byte-address bit is never decoded. The remaining twenty word-address bits are split across ten row lines and ten column lines. Two bit orderings can be selected. In the contiguous ordering, the low word bits form the row and the next bits form the column. In the interleaved ordering, row and column bits alternate, starting from the bottom.

A size input declares the bank as 128 kB, 512 kB or 2 MB. The two orderings react to a smaller bank in different ways. The contiguous ordering re-packs its fields, so that the column starts directly above the shortened row. The interleaved ordering keeps its mapping and only drops the top lines. Lines that the selected size does not use are driven low.

A one-cycle request latches the address, the ordering and the size. The block then walks through four phases: row shown, row strobe, column shown, column strobe. Both strobes then hold for a programmable number of cycles, and a one-cycle done pulse ends the access.

Top module: `dram_addr_mux`

## Requirements
- R1: After reset, `ma_out` is zero, and `ras_on`, `cas_on`, `done` and `busy` are all low.
- R2: With ordering 0 (contiguous) and a 2 MB bank (size code 2), the row is address bits 10..1 (row line 0 = bit 1) and the column is bits 20..11.
- R3: With ordering 0 and a 512 kB bank (size code 1), row lines 8..0 are address bits 9..1 and column lines 8..0 are bits 18..10. Row line 9 and column line 9 are zero.
- R4: With ordering 0 and a 128 kB bank (size code 0), row lines 7..0 are address bits 8..1 and column lines 7..0 are bits 16..9. Lines 9..8 of both are zero.
- R5: With ordering 1 (interleaved) and a 2 MB bank, row line j is address bit 2j+1 and column line j is address bit 2j+2, for j = 0..9.
- R6: With ordering 1 and a smaller bank, the interleaved mapping is unchanged. Line 9 (for 512 kB) or lines 9..8 (for 128 kB) of both row and column are forced to zero.
- R7: When `req` is sampled high while idle, the next cycle shows the row with `ras_on` low. The following cycle raises `ras_on`, with the row still shown. The next cycle shows the column with `cas_on` low. The cycle after that raises `cas_on`.
- R8: `ras_on` and `cas_on` stay high together for exactly HOLD_CYC cycles. Then `done` is high for one cycle with both strobes low, and the block returns to idle with `ma_out` zero.
- R9: The ordering and size are captured only when a request is accepted. Changing them during an access does not alter that access's column.
- R10: `req` asserted while `busy` is high is ignored, and the access in progress completes unchanged.
- R11: Size code 3 decodes the same as a 2 MB bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start an access (taken only while idle) |
| addr_hi | input | 20 | Byte address bits 20..1 (bit 0 is not decoded) |
| order_sel | input | 1 | 0 = contiguous, 1 = interleaved |
| bank_size | input | 2 | 0 = 128 kB, 1 = 512 kB, 2 or 3 = 2 MB |
| ma_out | output | 10 | Multiplexed DRAM address lines |
| ras_on | output | 1 | Row strobe, active high |
| cas_on | output | 1 | Column strobe, active high |
| done | output | 1 | One-cycle end-of-access pulse |
| busy | output | 1 | An access is in progress |

## Verification
A corrupted latch of the address or the configuration shows up within three cycles of the request, as a wrong row or column on `ma_out`. A fault in the phase sequencer appears at the first wrong edge of `ras_on`, `cas_on` or `done`: a phase shifted by one cycle, or a hold that is too short or too long. A change of ordering or size, or an extra request, made mid-access exposes any leak of live inputs into the latched state during the column phase of that same access. A size decode error shows as nonzero top lines, or as a column taken from the wrong address bits.

// File: rtl/dram_mux_pkg.sv
// Shared types for the DRAM address multiplexer.
// Assumes ten row and ten column lines; size codes 2 and 3 both mean full size.
package dram_mux_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_RAS  = 3'd2,
        ST_COL  = 3'd3,
        ST_CAS  = 3'd4,
        ST_DONE = 3'd5
    } phase_e;

    localparam logic [1:0] SZ_SMALL = 2'd0;
    localparam logic [1:0] SZ_MID   = 2'd1;

    // Number of top lines dropped for a given size code.
    function automatic logic [1:0] lines_dropped(input logic [1:0] size_code);
        case (size_code)
            SZ_SMALL: lines_dropped = 2'd2;
            SZ_MID:   lines_dropped = 2'd1;
            default:  lines_dropped = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dram_req_latch.sv
// Holds the word address and configuration for the access in progress.
// Assumes load is asserted only on the cycle a request is accepted.
module dram_req_latch #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              order_in,
    input  logic [1:0]        size_in,
    output logic [WORD_W-1:0] word_q,
    output logic              order_q,
    output logic [1:0]        size_q
);

    // Capture the request fields when a new access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            order_q <= 1'b0;
            size_q  <= 2'd2;
        end else if (load) begin
            word_q  <= word_in;
            order_q <= order_in;
            size_q  <= size_in;
        end
    end

    // R9: configuration and address stay put between accepted requests.
    a_r9_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(order_q) && $stable(size_q) && $stable(word_q)));

endmodule

// File: rtl/dram_line_map.sv
// Combinational map from word address to row and column lines.
// Builds the contiguous variant for each possible drop count and picks one;
// the interleaved variant is fixed wiring with the top lines masked.
module dram_line_map
    import dram_mux_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic [2*LINE_W-1:0] word,
    input  logic                order_il,
    input  logic [1:0]          size_code,
    output logic [LINE_W-1:0]   row_lines,
    output logic [LINE_W-1:0]   col_lines
);

    localparam int NUM_VAR = 3;

    logic [LINE_W-1:0] ct_row [NUM_VAR];
    logic [LINE_W-1:0] ct_col [NUM_VAR];
    logic [LINE_W-1:0] il_row;
    logic [LINE_W-1:0] il_col;
    logic [LINE_W-1:0] keep;
    logic [1:0]        drop;

    // Contiguous packing: row = low k bits, column = next k bits, k = LINE_W - d.
    for (genvar d = 0; d < NUM_VAR; d++) begin : g_contig
        for (genvar j = 0; j < LINE_W; j++) begin : g_line
            if (j < LINE_W - d) begin : g_used
                assign ct_row[d][j] = word[j];
                assign ct_col[d][j] = word[LINE_W - d + j];
            end else begin : g_unused
                assign ct_row[d][j] = 1'b0;
                assign ct_col[d][j] = 1'b0;
            end
        end
    end

    // Interleaved wiring: even word bits to row lines, odd word bits to column lines.
    for (genvar j = 0; j < LINE_W; j++) begin : g_il
        assign il_row[j] = word[2*j];
        assign il_col[j] = word[2*j + 1];
    end

    // Mask of lines that the selected size actually uses.
    always_comb begin
        drop = lines_dropped(size_code);
        keep = '1;
        if (drop == 2'd1) keep[LINE_W-1] = 1'b0;
        if (drop == 2'd2) keep[LINE_W-1 -: 2] = 2'b00;
    end

    // Select the ordering and apply the size.
    always_comb begin
        if (order_il) begin
            row_lines = il_row & keep;
            col_lines = il_col & keep;
        end else begin
            row_lines = ct_row[drop];
            col_lines = ct_col[drop];
        end
    end

endmodule

// File: rtl/dram_strobe_seq.sv
// Phase sequencer: row, row strobe, column, column strobe held HOLD_CYC
// cycles, then a done pulse. Assumes HOLD_CYC >= 1.
module dram_strobe_seq
    import dram_mux_pkg::*;
#(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic drive,
    output logic show_col,
    output logic ras_on,
    output logic cas_on,
    output logic done,
    output logic busy
);

    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    phase_e           state;
    logic [CNT_W-1:0] hold_cnt;

    assign accept = (state == ST_IDLE) && req;

    // Advance through the access phases and count the strobe hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hold_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req) state <= ST_ROW;
                ST_ROW:  state <= ST_RAS;
                ST_RAS:  state <= ST_COL;
                ST_COL: begin
                    state    <= ST_CAS;
                    hold_cnt <= '0;
                end
                ST_CAS: begin
                    if (hold_cnt == LAST) state <= ST_DONE;
                    else                  hold_cnt <= hold_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the pin-level controls from the phase.
    always_comb begin
        drive    = (state == ST_ROW) || (state == ST_RAS) || (state == ST_COL) || (state == ST_CAS);
        show_col = (state == ST_COL) || (state == ST_CAS);
        ras_on   = (state == ST_RAS) || (state == ST_COL) || (state == ST_CAS);
        cas_on   = (state == ST_CAS);
        done     = (state == ST_DONE);
        busy     = (state != ST_IDLE);
    end

    // R10: a request seen mid-access never restarts the row phase.
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> (state != ST_ROW));

    // R8: the hold counter never passes its last value.
    a_r8_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= LAST);

    // R8: done is followed by idle.
    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/dram_addr_mux.sv
// Top: DRAM row/column address multiplexer for one bank.
// Latches a request, maps it with the selected ordering and size, and drives
// the shared address lines in step with the row and column strobes.
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int HOLD_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [2*LINE_W:1]   addr_hi,
    input  logic                order_sel,
    input  logic [1:0]          bank_size,
    output logic [LINE_W-1:0]   ma_out,
    output logic                ras_on,
    output logic                cas_on,
    output logic                done,
    output logic                busy
);

    localparam int WORD_W = 2 * LINE_W;

    logic              accept, drive, show_col;
    logic [WORD_W-1:0] word_q;
    logic              order_q;
    logic [1:0]        size_q;
    logic [LINE_W-1:0] row_lines, col_lines;

    dram_req_latch #(.WORD_W(WORD_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .word_in  (addr_hi),
        .order_in (order_sel),
        .size_in  (bank_size),
        .word_q   (word_q),
        .order_q  (order_q),
        .size_q   (size_q)
    );

    dram_line_map #(.LINE_W(LINE_W)) u_map (
        .word      (word_q),
        .order_il  (order_q),
        .size_code (size_q),
        .row_lines (row_lines),
        .col_lines (col_lines)
    );

    dram_strobe_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .accept   (accept),
        .drive    (drive),
        .show_col (show_col),
        .ras_on   (ras_on),
        .cas_on   (cas_on),
        .done     (done),
        .busy     (busy)
    );

    // Put row or column on the shared lines, zero when idle.
    always_comb begin
        if (!drive)        ma_out = '0;
        else if (show_col) ma_out = col_lines;
        else               ma_out = row_lines;
    end

    // R7: the column strobe only ever rides on an active row strobe.
    a_r7_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        cas_on |-> ras_on);

    // R7: the row strobe rises on lines that were already stable.
    a_r7_row_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_on) |-> $stable(ma_out));

    // R7: column strobe rises only after the row strobe was already up.
    a_r7_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_on) |-> $past(ras_on));

    // R8: strobes are low during the done pulse.
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ras_on && !cas_on));

    // R4/R6: a 128 kB bank never drives its top two lines.
    a_r6_small_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == SZ_SMALL) |-> (ma_out[LINE_W-1 -: 2] == 2'b00));

endmodule

// File: tb/sim_dram_addr_mux.sv
`timescale 1ns/1ps
module sim_dram_addr_mux;

    localparam int LW   = 10;
    localparam int HOLD = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [20:1]   addr_hi = '0;
    logic          order_sel = 1'b0;
    logic [1:0]    bank_size = 2'd2;
    logic [LW-1:0] ma_out;
    logic          ras_on, cas_on, done, busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dram_addr_mux #(.LINE_W(LW), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr_hi(addr_hi),
        .order_sel(order_sel), .bank_size(bank_size), .ma_out(ma_out),
        .ras_on(ras_on), .cas_on(cas_on), .done(done), .busy(busy)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int kept(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 9 : 10;
    endfunction

    function automatic logic [9:0] exp_line(input logic [20:1] a, input bit il, input logic [1:0] sz, input bit col);
        logic [19:0] w = a;
        int k = kept(sz);
        logic [9:0] r = '0;
        for (int j = 0; j < k; j++) begin
            if (il) r[j] = col ? w[2*j+1] : w[2*j];
            else    r[j] = col ? w[k+j] : w[j];
        end
        return r;
    endfunction

    function automatic string map_tag(input bit il, input logic [1:0] sz);
        if (sz == 2'd3) return "R11";
        if (il) return (sz == 2'd2) ? "R5" : "R6";
        return (sz == 2'd2) ? "R2" : (sz == 2'd1) ? "R3" : "R4";
    endfunction

    // One access; optionally disturb config and req mid-access (R9, R10).
    task automatic access(input logic [20:1] a, input bit il, input logic [1:0] sz, input bit disturb);
        logic [9:0] er = exp_line(a, il, sz, 1'b0);
        logic [9:0] ec = exp_line(a, il, sz, 1'b1);
        string mt = map_tag(il, sz);
        @(negedge clk);
        addr_hi = a; order_sel = il; bank_size = sz; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(mt, "row", ma_out, er);
        chk("R7", "ras in row phase", ras_on, 1'b0);
        chk("R7", "busy", busy, 1'b1);
        @(negedge clk);
        chk("R7", "ras up", ras_on, 1'b1);
        chk("R7", "row held", ma_out, er);
        if (disturb) begin
            order_sel = ~il; bank_size = sz + 2'd1; addr_hi = ~a; req = 1'b1;
        end
        @(negedge clk);
        req = 1'b0;
        chk(disturb ? "R9" : mt, "column", ma_out, ec);
        chk("R7", "cas low in col phase", cas_on, 1'b0);
        chk("R7", "ras held", ras_on, 1'b1);
        for (int i = 0; i < HOLD; i++) begin
            @(negedge clk);
            chk("R8", "cas held", cas_on, 1'b1);
            chk("R8", "ras held", ras_on, 1'b1);
            chk(disturb ? "R10" : mt, "column held", ma_out, ec);
        end
        @(negedge clk);
        chk("R8", "done", done, 1'b1);
        chk("R8", "strobes low", {ras_on, cas_on}, 2'b00);
        @(negedge clk);
        chk("R8", "idle", {busy, done}, 2'b00);
        chk("R8", "lines zero", ma_out, 10'd0);
    endtask

    initial begin
        logic [31:0] s;
        s = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk("R1", "ma", ma_out, 10'd0);
        chk("R1", "strobes", {ras_on, cas_on, done, busy}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after release", {ras_on, cas_on, done, busy}, 4'b0000);
        // Directed: bit patterns that expose each line.
        access(20'hFFFFF, 1'b0, 2'd2, 1'b0);   // R2
        access(20'h00204, 1'b0, 2'd0, 1'b0);   // R4 wrap-point pattern
        access(20'h00204, 1'b0, 2'd1, 1'b0);   // R3
        access(20'hFFFFF, 1'b0, 2'd1, 1'b0);   // R3 top zero
        access(20'hFFFFF, 1'b0, 2'd0, 1'b0);   // R4 top zero
        access(20'h55555, 1'b1, 2'd2, 1'b0);   // R5
        access(20'hAAAAA, 1'b1, 2'd2, 1'b0);   // R5
        access(20'hFFFFF, 1'b1, 2'd1, 1'b0);   // R6
        access(20'hFFFFF, 1'b1, 2'd0, 1'b0);   // R6
        access(20'h40004, 1'b1, 2'd0, 1'b0);   // R6
        access(20'hC3A5F, 1'b0, 2'd3, 1'b0);   // R11
        access(20'hC3A5F, 1'b1, 2'd3, 1'b0);   // R11
        access(20'h12345, 1'b0, 2'd1, 1'b1);   // R9, R10
        access(20'h6789A, 1'b1, 2'd0, 1'b1);   // R9, R10
        // Random mix.
        for (int n = 0; n < 60; n++) begin
            logic [31:0] v = $urandom;
            access(v[19:0], v[20], v[22:21], v[23]);
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule